// File: doc/BRIEF.md
# Multiply-Accumulate Unit

A single-cycle multiply-accumulate datapath for 16-bit operands feeding a 40-bit accumulator. On each cycle that the valid strobe is high, the unit forms a product of operand X and operand Y. Each operand is read as signed or unsigned according to its own select. The unit then stores one of these: the product alone, the accumulator plus the product, the accumulator minus the product, the square of X, or zero. When both operands are signed, the product is read as a fractional value and is doubled.

The new accumulator value can be rounded at the boundary between the upper and lower 16-bit fields. Rounding can run in unbiased mode, which rounds a tie to even, or in biased mode, which always rounds a tie up. The accumulator is shown as three fields: an 8-bit guard field, a 16-bit upper field and a 16-bit lower field. A flag reports when the value no longer fits the signed upper-plus-lower range.

Top module: `mac_unit`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, all result fields and the flag read zero.
- R2: Opcode 0 (multiply) loads the product into the accumulator. The result is visible after the next rising clock edge.
- R3: Opcode 1 (multiply-add) stores the old accumulator plus the product.
- R4: Opcode 2 (multiply-subtract) stores the old accumulator minus the product, in 40-bit two's complement.
- R5: Opcode 3 (square) stores X times X. It uses x_signed_i for both factors and ignores y_i and y_signed_i.
- R6: Opcode 4 (clear) sets the accumulator to zero in one cycle.
- R7: When valid_i is low, the accumulator holds its value. Opcodes 5 to 7 with valid_i high also leave it unchanged.
- R8: The product is doubled only when both operands are signed. A mixed-sign or unsigned product is not shifted.
- R9: With round_en_i high, 0x8000 is added to the 40-bit result before it is stored.
- R10: A tie occurs when the low 16 bits of the unrounded result equal 0x8000. With round_bias_i low, a tie also clears bit 16 of the rounded value. With round_bias_i high, bit 16 is left as the addition produced it.
- R11: ovf_o is high exactly when accumulator bits 39 down to 31 are not all equal.
- R12: res_ovf_o shows bits 39:32, res_hi_o shows bits 31:16 and res_lo_o shows bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| x_i | input | 16 | Operand X |
| y_i | input | 16 | Operand Y |
| x_signed_i | input | 1 | X is two's complement |
| y_signed_i | input | 1 | Y is two's complement |
| round_en_i | input | 1 | Round the stored result |
| round_bias_i | input | 1 | Biased tie handling |
| res_ovf_o | output | 8 | Guard field, bits 39:32 |
| res_hi_o | output | 16 | Upper field, bits 31:16 |
| res_lo_o | output | 16 | Lower field, bits 15:0 |
| ovf_o | output | 1 | Out-of-range flag |

## Verification
Accumulation and rounding act in the same cycle: a multiply-add or multiply-subtract with round_en_i high rounds the new sum, not the product. The bench provokes this with multiply-add steps whose sum lands exactly on a 0x8000 tie. It checks that the stored value is the tie rounded to even. Fractional doubling and the overflow flag also coincide when the square of the most negative value is doubled to 2^31. The bench checks both the doubled value and the raised flag from that single step.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    MAC_OP_MUL = 3'd0,
    MAC_OP_ADD = 3'd1,
    MAC_OP_SUB = 3'd2,
    MAC_OP_SQR = 3'd3,
    MAC_OP_CLR = 3'd4
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int W = 16,
  localparam int P = 2 * W + 2
) (
  input  logic                x_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic                a_signed_i,
  input  logic                b_signed_i,
  input  logic                sqr_i,
  output logic signed [P-1:0] prod_o
);
  logic [W-1:0]        b_sel;
  logic                b_sgn;
  logic signed [P-1:0] a_ext, b_ext, raw;

  // square reuses operand A and its sign select for both factors
  assign b_sel = sqr_i ? a_i : b_i;
  assign b_sgn = sqr_i ? a_signed_i : b_signed_i;
  assign a_ext = {{(W+2){a_signed_i & a_i[W-1]}}, a_i};
  assign b_ext = {{(W+2){b_sgn & b_sel[W-1]}}, b_sel};
  assign raw   = a_ext * b_ext;
  // fractional alignment for signed x signed
  assign prod_o = (a_signed_i & b_sgn) ? (raw <<< 1) : raw;

  logic unused;
  assign unused = x_i;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int W = 16,
  parameter int A = 40,
  localparam int P = 2 * W + 2
) (
  input  mac_op_e             op_i,
  input  logic [A-1:0]        acc_i,
  input  logic signed [P-1:0] prod_i,
  output logic [A-1:0]        sum_o
);
  logic [A-1:0] ext;
  assign ext = {{(A-P){prod_i[P-1]}}, prod_i};

  always_comb begin
    unique case (op_i)
      MAC_OP_ADD: sum_o = acc_i + ext;
      MAC_OP_SUB: sum_o = acc_i - ext;
      default:    sum_o = ext;
    endcase
  end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int W = 16,
  parameter int A = 40
) (
  input  logic [A-1:0] val_i,
  input  logic         en_i,
  input  logic         bias_i,
  output logic [A-1:0] val_o
);
  localparam logic [A-1:0] HALF = {{(A-W){1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic         tie;
  logic [A-1:0] bumped;

  assign tie = (val_i[W-1:0] == HALF[W-1:0]);

  always_comb begin
    bumped = val_i + HALF;
    if (!bias_i && tie) bumped[W] = 1'b0;
    val_o = en_i ? bumped : val_i;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  localparam int GRD_W = ACC_W - 2 * OP_W,
  localparam int PRD_W = 2 * OP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [OP_W-1:0]  x_i,
  input  logic [OP_W-1:0]  y_i,
  input  logic             x_signed_i,
  input  logic             y_signed_i,
  input  logic             round_en_i,
  input  logic             round_bias_i,
  output logic [GRD_W-1:0] res_ovf_o,
  output logic [OP_W-1:0]  res_hi_o,
  output logic [OP_W-1:0]  res_lo_o,
  output logic             ovf_o
);
  mac_op_e                 op;
  logic [ACC_W-1:0]        acc_q, sum, rnd;
  logic signed [PRD_W-1:0] prod;

  assign op = mac_op_e'(op_i);

  mac_mult #(.W(OP_W)) u_mult (
    .x_i       (1'b0),
    .a_i       (x_i),
    .b_i       (y_i),
    .a_signed_i(x_signed_i),
    .b_signed_i(y_signed_i),
    .sqr_i     (op == MAC_OP_SQR),
    .prod_o    (prod)
  );

  mac_accum #(.W(OP_W), .A(ACC_W)) u_accum (
    .op_i  (op),
    .acc_i (acc_q),
    .prod_i(prod),
    .sum_o (sum)
  );

  mac_round #(.W(OP_W), .A(ACC_W)) u_round (
    .val_i (sum),
    .en_i  (round_en_i),
    .bias_i(round_bias_i),
    .val_o (rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (valid_i) begin
      case (op)
        MAC_OP_CLR:                                     acc_q <= '0;
        MAC_OP_MUL, MAC_OP_ADD, MAC_OP_SUB, MAC_OP_SQR: acc_q <= rnd;
        default:                                        acc_q <= acc_q;
      endcase
    end
  end

  assign res_ovf_o = acc_q[ACC_W-1 -: GRD_W];
  assign res_hi_o  = acc_q[2*OP_W-1 -: OP_W];
  assign res_lo_o  = acc_q[OP_W-1:0];
  // guard bits plus the sign of the upper field must all agree
  assign ovf_o = !((&acc_q[ACC_W-1:2*OP_W-1]) || !(|acc_q[ACC_W-1:2*OP_W-1]));
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W  = 16,
  parameter int GRD_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [OP_W-1:0]  x_i,
  input logic             round_en_i,
  input logic [GRD_W-1:0] res_ovf_o,
  input logic [OP_W-1:0]  res_hi_o,
  input logic [OP_W-1:0]  res_lo_o,
  input logic             ovf_o
);
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (res_ovf_o == '0 && res_hi_o == '0 && res_lo_o == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_ovf_o) && $stable(res_hi_o) && $stable(res_lo_o))); // R7

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (res_ovf_o == '0 && res_hi_o == '0 && res_lo_o == '0)); // R6

  AST_ADD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1 && x_i == '0 && !round_en_i) |=> ($stable(res_hi_o) && $stable(res_lo_o))); // R3

  AST_SUB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && x_i == '0 && !round_en_i) |=> ($stable(res_hi_o) && $stable(res_lo_o))); // R4

  AST_SQR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && x_i == '0 && !round_en_i) |=> (res_hi_o == '0 && res_lo_o == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |-> (res_ovf_o == {GRD_W{res_hi_o[OP_W-1]}})); // R11
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .GRD_W(GRD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .x_i       (x_i),
  .round_en_i(round_en_i),
  .res_ovf_o (res_ovf_o),
  .res_hi_o  (res_hi_o),
  .res_lo_o  (res_lo_o),
  .ovf_o     (ovf_o)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] x_i = '0, y_i = '0;
  logic        x_signed_i = 1'b0, y_signed_i = 1'b0;
  logic        round_en_i = 1'b0, round_bias_i = 1'b0;
  logic [7:0]  res_ovf_o;
  logic [15:0] res_hi_o, res_lo_o;
  logic        ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  mac_unit dut (.*);

  // op, x, y, xs, ys, rnd, bias, expected accumulator
  localparam int NV = 18;
  localparam logic [78:0] VEC [NV] = '{
    {3'd0, 16'h0003, 16'h0005, 4'b0000, 40'h00_0000_000F}, // R2
    {3'd1, 16'h0002, 16'h0004, 4'b0000, 40'h00_0000_0017}, // R3
    {3'd2, 16'h000A, 16'h0003, 4'b0000, 40'hFF_FFFF_FFF9}, // R4
    {3'd0, 16'h4000, 16'h4000, 4'b1100, 40'h00_2000_0000}, // R8 doubled
    {3'd0, 16'hFFFF, 16'h0002, 4'b1000, 40'hFF_FFFF_FFFE}, // R8 mixed
    {3'd0, 16'hFFFF, 16'hFFFF, 4'b0000, 40'h00_FFFE_0001}, // R11
    {3'd3, 16'h8000, 16'h1234, 4'b1000, 40'h00_8000_0000}, // R5 + R8
    {3'd3, 16'h0003, 16'hFFFF, 4'b0100, 40'h00_0000_0009}, // R5 y ignored
    {3'd4, 16'h1111, 16'h2222, 4'b0000, 40'h00_0000_0000}, // R6
    {3'd0, 16'h0001, 16'h8000, 4'b0010, 40'h00_0000_0000}, // R10 tie unbiased
    {3'd0, 16'h0001, 16'h8000, 4'b0011, 40'h00_0001_0000}, // R10 tie biased
    {3'd0, 16'h0003, 16'h8000, 4'b0010, 40'h00_0002_0000}, // R10 tie even
    {3'd0, 16'h0001, 16'h7FFF, 4'b0010, 40'h00_0000_FFFF}, // R9
    {3'd0, 16'h0001, 16'h9000, 4'b0010, 40'h00_0001_1000}, // R9
    {3'd5, 16'h0007, 16'h0007, 4'b0000, 40'h00_0001_1000}, // R7 undefined op
    {3'd1, 16'h0001, 16'h7000, 4'b0010, 40'h00_0002_0000}, // R3 + R10
    {3'd2, 16'h0004, 16'h8000, 4'b1000, 40'h00_0000_0000}, // R4 mixed
    {3'd2, 16'hFFFF, 16'hFFFF, 4'b0000, 40'hFF_0001_FFFF}  // R4 + R11
  };

  task automatic check(input string req, input logic [39:0] exp);
    logic exp_ovf;
    logic [39:0] got;
    got = {res_ovf_o, res_hi_o, res_lo_o};
    exp_ovf = !((&exp[39:31]) || !(|exp[39:31]));
    n_chk++;
    if (got !== exp || ovf_o !== exp_ovf) begin
      n_bad++;
      $display("FAIL %s: got %h ovf %b, expected %h ovf %b", req, got, ovf_o, exp, exp_ovf);
    end
  endtask

  task automatic drive(input logic v, input logic [78:0] e);
    valid_i      = v;
    op_i         = e[78:76];
    x_i          = e[75:60];
    y_i          = e[59:44];
    x_signed_i   = e[43];
    y_signed_i   = e[42];
    round_en_i   = e[41];
    round_bias_i = e[40];
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", 40'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 40'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i]);
      check($sformatf("R12 vector %0d", i), VEC[i][39:0]);
    end

    drive(1'b1, {3'd0, 16'h0005, 16'h0007, 4'b0000, 40'h0});
    check("R2 load", 40'h23);
    drive(1'b0, {3'd4, 16'h0000, 16'h0000, 4'b0000, 40'h0});
    check("R7 idle clear", 40'h23);
    drive(1'b0, {3'd1, 16'h0100, 16'h0100, 4'b0000, 40'h0});
    check("R7 idle add", 40'h23);
    drive(1'b1, {3'd7, 16'h0100, 16'h0100, 4'b0000, 40'h0});
    check("R7 op 7", 40'h23);
    drive(1'b1, {3'd1, 16'h0000, 16'hFFFF, 4'b0000, 40'h0});
    check("R3 zero product", 40'h23);

    valid_i = 1'b0;
    #3 rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset", 40'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 release", 40'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule